// File: doc/BRIEF.md
# Unsigned Array Multiplier with Lookahead Final Adder

This block multiplies two unsigned operands of equal width and returns the full double-width product in the same cycle. It has no clock and no stored state. Every partial-product bit is the AND of one multiplier bit and one multiplicand bit. Row i of the partial products comes from multiplier bit i and carries a weight of 2^i.

The rows are folded together in a carry-save array of adder cells. Each stage takes the running sum shifted one place, the carries of the stage before, and one new partial-product row. Where a full adder has a spare input, the partial-product bit goes into its carry input. Columns where only two bits meet use half adders. The least significant product bit of each stage leaves the array as a finished product bit. The sum and carry vectors left after the last stage go to a carry-lookahead adder, which produces the upper half of the product.

The lookahead adder forms generate and propagate terms for each bit. Inside each 4-bit group it writes every carry as a flat sum of products. Group carries are chained from group to group, so operand widths that are not a multiple of four are handled by a narrower last group. The operand width is a parameter, with a default of 4 and a minimum of 2.

Top module: `mul_array_top`

## Requirements
- R1: For every pair of WIDTH-bit unsigned operands, `product` equals their exact 2*WIDTH-bit unsigned product, and the final lookahead adder never produces a carry out of its top bit.
- R2: Row i is selected by multiplier bit i alone: when `mplier` has only bit i set, `product` equals `mcand` shifted left by i places (`mplier` = 1 gives `product` = `mcand`).
- R3: A zero operand on either input (all bits 0) gives a product of all zeros, whatever the other operand holds.
- R4: `product[0]` equals `mcand[0] & mplier[0]` for all inputs.
- R5: All-ones operands give 2^(2*WIDTH) - 2^(WIDTH+1) + 1, the case where carries travel across every lookahead group.
- R6: The output is a pure function of the present inputs: after an input change it settles with no clock edge, and a second change within the same clock period is reflected as well.
- R7: Swapping the two operands leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Unsigned multiplicand |
| mplier | input | WIDTH | Unsigned multiplier; bit i selects partial-product row i |
| product | output | 2*WIDTH | Unsigned product of the two operands |

## Verification
The bench instantiates the block three times, with WIDTH set to 4, 6 and 12. At WIDTH 4 the whole operand space of 256 pairs can be checked one by one, including every single-bit multiplier row. WIDTH 6 leaves a partial second lookahead group, so a carry has to cross a group boundary into a narrower group. WIDTH 12 chains three full groups and is exercised with random operand pairs plus all-ones, one-hot and zero corners.

// File: rtl/mul_pkg.sv
package mul_pkg;
    // Width of one carry-lookahead group in the final adder.
    localparam int CLA_GROUP = 4;
endpackage

// File: rtl/mul_pp_matrix.sv
// AND-plane that forms every partial-product bit.
// Flat index i*N+j holds mplier[i] & mcand[j] (weight 2^(i+j)).
module mul_pp_matrix #(
    parameter int N = 4
) (
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [N*N-1:0] pp
);
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_bit
            assign pp[i*N+j] = mplier[i] & mcand[j];
        end
    end
endmodule

// File: rtl/mul_add_cell.sv
// One adder cell. FULL=1 sums three bits; FULL=0 is a half adder on a and b.
module mul_add_cell #(
    parameter bit FULL = 1'b1
) (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    if (FULL) begin : g_full
        assign s  = a ^ b ^ ci;
        assign co = (a & b) | (a & ci) | (b & ci);
    end else begin : g_half
        logic unused_ci;
        assign unused_ci = ci;
        assign s  = a ^ b;
        assign co = a & b;
    end
endmodule

// File: rtl/mul_csa_array.sv
// Carry-save reduction array. After stage i, s_row[j] has weight 2^(i+j)
// and c_row[j] has weight 2^(i+j+1). Bit 0 of each stage is a final product bit.
module mul_csa_array #(
    parameter int N = 4
) (
    input  logic [N*N-1:0] pp,
    output logic [N-1:0]   low_bits,
    output logic [N-1:0]   x_vec,
    output logic [N-1:0]   y_vec
);
    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N-1:0] s_row;
        logic [N-1:0] c_row;
        if (i == 0) begin : g_top
            assign s_row = pp[N-1:0];
            assign c_row = '0;
        end else begin : g_add
            for (genvar j = 0; j < N; j++) begin : g_col
                if (j == N-1 && i == 1) begin : g_pass
                    assign s_row[j] = pp[i*N+j];
                    assign c_row[j] = 1'b0;
                end else if (j == N-1) begin : g_edge
                    mul_add_cell #(.FULL(1'b0)) u_cell (
                        .a  (g_row[i-1].c_row[j]),
                        .b  (pp[i*N+j]),
                        .ci (1'b0),
                        .s  (s_row[j]),
                        .co (c_row[j])
                    );
                end else if (i == 1) begin : g_half
                    mul_add_cell #(.FULL(1'b0)) u_cell (
                        .a  (g_row[i-1].s_row[j+1]),
                        .b  (pp[i*N+j]),
                        .ci (1'b0),
                        .s  (s_row[j]),
                        .co (c_row[j])
                    );
                end else begin : g_full
                    // partial-product bit enters on the carry input
                    mul_add_cell #(.FULL(1'b1)) u_cell (
                        .a  (g_row[i-1].s_row[j+1]),
                        .b  (g_row[i-1].c_row[j]),
                        .ci (pp[i*N+j]),
                        .s  (s_row[j]),
                        .co (c_row[j])
                    );
                end
            end
        end
        assign low_bits[i] = s_row[0];
    end

    assign x_vec = {1'b0, g_row[N-1].s_row[N-1:1]};
    assign y_vec = g_row[N-1].c_row;
endmodule

// File: rtl/mul_cla_adder.sv
// Carry-lookahead adder: flat sum-of-products carries inside each group,
// group carries chained. The last group is narrower when W is not a multiple.
module mul_cla_adder
    import mul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = (W + CLA_GROUP - 1) / CLA_GROUP;

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    assign gen  = x & y;
    assign prop = x ^ y;

    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        localparam int BASE = gi * CLA_GROUP;
        localparam int GW   = (W - BASE < CLA_GROUP) ? (W - BASE) : CLA_GROUP;
        logic          cin_grp;
        logic [GW-1:0] cg;
        logic [GW-1:0] sm;

        if (gi == 0) begin : g_c0
            assign cin_grp = 1'b0;
        end else begin : g_cn
            assign cin_grp = g_grp[gi-1].cg[CLA_GROUP-1];
        end

        always_comb begin
            logic acc;
            logic term;
            for (int k = 0; k < GW; k++) begin
                acc = cin_grp;
                for (int m = 0; m <= k; m++) acc = acc & prop[BASE+m];
                for (int m = 0; m <= k; m++) begin
                    term = gen[BASE+m];
                    for (int q = m + 1; q <= k; q++) term = term & prop[BASE+q];
                    acc = acc | term;
                end
                cg[k] = acc;
            end
        end

        always_comb begin
            for (int k = 0; k < GW; k++) begin
                sm[k] = prop[BASE+k] ^ ((k == 0) ? cin_grp : cg[(k == 0) ? 0 : k-1]);
            end
        end

        assign sum[BASE +: GW] = sm;
    end

    assign cout = g_grp[NG-1].cg[W - (NG-1)*CLA_GROUP - 1];
endmodule

// File: rtl/mul_array_top.sv
// Combinational unsigned array multiplier, WIDTH >= 2.
module mul_array_top #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);
    localparam int PPW = WIDTH * WIDTH;

    logic [PPW-1:0]   pp;
    logic [WIDTH-1:0] low_bits;
    logic [WIDTH-1:0] x_vec;
    logic [WIDTH-1:0] y_vec;
    logic [WIDTH-1:0] high_bits;
    logic             cla_cout;

    mul_pp_matrix #(.N(WIDTH)) u_pp (
        .mcand  (mcand),
        .mplier (mplier),
        .pp     (pp)
    );

    mul_csa_array #(.N(WIDTH)) u_csa (
        .pp       (pp),
        .low_bits (low_bits),
        .x_vec    (x_vec),
        .y_vec    (y_vec)
    );

    mul_cla_adder #(.W(WIDTH)) u_cla (
        .x    (x_vec),
        .y    (y_vec),
        .sum  (high_bits),
        .cout (cla_cout)
    );

    assign product = {high_bits, low_bits};
endmodule

// File: rtl/mul_array_chk.sv
// Property checker, bound into every mul_array_top instance.
module mul_array_chk #(
    parameter int N = 4
) (
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic [2*N-1:0] product,
    input logic           cla_cout
);
    logic [2*N-1:0] wide_a;
    logic [2*N-1:0] wide_b;
    assign wide_a = {{N{1'b0}}, mcand};
    assign wide_b = {{N{1'b0}}, mplier};

    always_comb begin
        a_r1_exact: assert (product == wide_a * wide_b)
            else $error("product %0d differs from %0d*%0d", product, mcand, mplier);
        a_r1_cla_no_carry: assert (!cla_cout)
            else $error("lookahead adder carried out");
        a_r2_unit_row: assert (mplier != {{(N-1){1'b0}}, 1'b1} || product == wide_a)
            else $error("unit multiplier did not pass multiplicand");
        a_r3_zero_operand: assert ((mcand != '0 && mplier != '0) || product == '0)
            else $error("zero operand gave nonzero product");
        a_r4_lsb: assert (product[0] == (mcand[0] & mplier[0]))
            else $error("product bit 0 wrong");
    end
endmodule

bind mul_array_top mul_array_chk #(.N(WIDTH)) u_chk (
    .mcand    (mcand),
    .mplier   (mplier),
    .product  (product),
    .cla_cout (cla_cout)
);

// File: tb/sim_mul_array_top.sv
`timescale 1ns/1ps
module sim_mul_array_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    logic [5:0]  a6 = '0, b6 = '0;
    logic [11:0] p6;
    logic [11:0] a12 = '0, b12 = '0;
    logic [23:0] p12;

    mul_array_top #(.WIDTH(4))  u0 (.mcand(a4),  .mplier(b4),  .product(p4));
    mul_array_top #(.WIDTH(6))  u1 (.mcand(a6),  .mplier(b6),  .product(p6));
    mul_array_top #(.WIDTH(12)) u2 (.mcand(a12), .mplier(b12), .product(p12));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    // {mcand, mplier, product} for WIDTH=4
    localparam logic [15:0] VEC [0:11] = '{
        16'h0000, 16'hF000, 16'h0900, 16'h1101, 16'hFFE1, 16'h7315,
        16'h5A32, 16'hCC90, 16'h9848, 16'hB42C, 16'h6D4E, 16'hF10F
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // reset-state check: operands held at zero
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset-zero w4", 64'(p4), 64'd0);
        check("R3 reset-zero w12", 64'(p12), 64'd0);
        rst_n = 1'b1;

        // table walk (R1, R3, R5, R2)
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            a4 <= VEC[k][15:12];
            b4 <= VEC[k][11:8];
            @(negedge clk);
            check("R1 table w4", 64'(p4), 64'(VEC[k][7:0]));
        end

        // exhaustive WIDTH=4: R1 exact, R4 lsb, R7 swap
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                logic [7:0] fwd;
                @(posedge clk);
                a4 <= 4'(x);
                b4 <= 4'(y);
                @(negedge clk);
                check("R1 exhaustive w4", 64'(p4), 64'(x * y));
                check("R4 lsb w4", 64'(p4[0]), 64'(x & y & 1));
                fwd = p4;
                a4 = 4'(y);
                b4 = 4'(x);
                #1;
                check("R7 swap w4", 64'(p4), 64'(fwd));
            end
        end

        // R2 one-hot multiplier rows for every width
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); a4 <= 4'd11; b4 <= 4'(1 << i);
            @(negedge clk); check("R2 row w4", 64'(p4), 64'(11) << i);
        end
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); a6 <= 6'd45; b6 <= 6'(1 << i);
            @(negedge clk); check("R2 row w6", 64'(p6), 64'(45) << i);
        end
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); a12 <= 12'hA5B; b12 <= 12'(1 << i);
            @(negedge clk); check("R2 row w12", 64'(p12), 64'(12'hA5B) << i);
        end

        // R5 all-ones
        @(posedge clk); a6 <= '1; b6 <= '1; a12 <= '1; b12 <= '1;
        @(negedge clk);
        check("R5 ones w6", 64'(p6), 64'd3969);
        check("R5 ones w12", 64'(p12), 64'd16769025);

        // R3 one zero operand against a full one
        @(posedge clk); a12 <= '0; b12 <= 12'hFFF; a6 <= 6'h3F; b6 <= '0;
        @(negedge clk);
        check("R3 zero mcand w12", 64'(p12), 64'd0);
        check("R3 zero mplier w6", 64'(p6), 64'd0);

        // random WIDTH=6 and WIDTH=12 (R1, R7)
        for (int k = 0; k < 300; k++) begin
            logic [5:0]  ra6, rb6;
            logic [11:0] ra12, rb12;
            logic [23:0] keep12;
            ra6 = 6'($urandom); rb6 = 6'($urandom);
            ra12 = 12'($urandom); rb12 = 12'($urandom);
            @(posedge clk);
            a6 <= ra6; b6 <= rb6; a12 <= ra12; b12 <= rb12;
            @(negedge clk);
            check("R1 random w6", 64'(p6), 64'(ra6) * 64'(rb6));
            check("R1 random w12", 64'(p12), 64'(ra12) * 64'(rb12));
            keep12 = p12;
            a12 = rb12; b12 = ra12;
            #1;
            check("R7 swap w12", 64'(p12), 64'(keep12));
        end

        // R6 two changes inside one clock period, no edge between
        @(negedge clk);
        a12 = 12'd1000; b12 = 12'd3000;
        #1;
        check("R6 settle first w12", 64'(p12), 64'd3000000);
        a12 = 12'd4095; b12 = 12'd2;
        #1;
        check("R6 settle second w12", 64'(p12), 64'd8190);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule